// File: doc/BRIEF.md
# UART Flow and Modem Control Unit

This block is the control side of a high-speed serial port. It holds the received bytes in a small queue, raises a data-ready request once enough bytes are waiting, and chooses which byte goes next to the transmit shifter: a byte from the transmit holding buffer, or a received byte looped straight back. It also drives the two modem output pins (terminal ready and the request/ready pin). Transmission may be paused by the clear-to-send input or by in-band stop/resume characters.

One 32-bit control word sets its behaviour. Its fields are the queue enable (bit 0), the data-ready trigger (bits 23:22), the terminal-ready level (bit 24), the request level (bit 25), two reserved bits (27:26, written as zero), pin-managed flow (bit 28), character-managed flow (bit 29), loopback echo (bit 30) and the meaning of the request pin (bit 31). The stop and resume characters come in on their own inputs. The baud generator and the bit shifters sit outside the block. They are reached through single-cycle byte strobes.

Top module: `uart_flowctl`

## Requirements
- R1: While reset is held and right after it, `pin_dtr` and `pin_rts` are high, `rx_fill` is 0, and `rx_ready_req` and `tx_out_valid` are 0.
- R2: When bit 0 is 1, `rx_ready_req` is 1 exactly when `rx_fill` is at or above the trigger level chosen by bits 23:22 (00 gives 1, 01 gives 8, 10 gives 18, 11 gives 28). When bit 0 is 0, it is 1 exactly when `rx_fill` is not 0.
- R3: Received bytes are read out first in, first out. The queue holds 32 bytes when bit 0 is 1 and one byte when bit 0 is 0. A byte that arrives while the queue is at capacity is dropped and `rx_fill` does not change.
- R4: One clock after the control word changes, `pin_dtr` is low when bit 24 is 1 and high when it is 0. Bits 27:26 have no effect on any output.
- R5: With bit 31 at 0 and bit 28 at 0, `pin_rts` one clock later is low when bit 25 is 1 and high when it is 0.
- R6: With bit 28 at 1 and bit 31 at 0, bit 25 is ignored and `pin_rts` goes low one clock after `tx_buf_valid` is 1 while `cts_n` is 0; otherwise it is high. While bit 28 is 1 and `cts_n` is 1, no byte is taken from the transmit buffer.
- R7: With bit 31 at 1, `pin_rts` one clock later is high when the queue is full (bit 0 at 1) or when it is not empty (bit 0 at 0), and low otherwise.
- R8: With bit 29 at 1, a received byte equal to `xoff_char` stops transmit-buffer transfers, and a byte equal to `xon_char` restarts them. Neither byte is stored. With bit 29 at 0, both are stored as data.
- R9: With bit 30 at 1, every stored received byte also appears on `tx_out_data` with `tx_out_valid` one clock later, and `tx_buf_ack` stays 0.
- R10: Without echo, when `tx_buf_valid`, `tx_shift_ready` and the flow permission are all true, `tx_buf_ack` is 1 in that cycle, and in the next cycle `tx_out_valid` is 1 with that byte on `tx_out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 32 | Control word |
| xon_char | input | 8 | Resume character |
| xoff_char | input | 8 | Stop character |
| rx_in_valid | input | 1 | Received byte strobe from the shifter |
| rx_in_data | input | 8 | Received byte |
| rx_rd | input | 1 | Consumer takes the head byte |
| rx_out_data | output | 8 | Head byte of the queue |
| rx_fill | output | 6 | Bytes waiting |
| rx_ready_req | output | 1 | Data-ready request |
| tx_buf_valid | input | 1 | Transmit holding buffer has a byte |
| tx_buf_data | input | 8 | Transmit holding buffer byte |
| tx_buf_ack | output | 1 | Byte taken from the transmit buffer |
| tx_shift_ready | input | 1 | Transmit shifter can accept a byte |
| tx_out_valid | output | 1 | Byte strobe to the transmit shifter |
| tx_out_data | output | 8 | Byte to the transmit shifter |
| cts_n | input | 1 | Clear-to-send, active low |
| pin_dtr | output | 1 | Terminal-ready pin level |
| pin_rts | output | 1 | Request/ready pin level |

## Verification
The full-queue case under the ready-to-receive pin meaning is the hardest to reach. The pin only rises after 32 bytes have been written with no reads in between, and it falls one clock after the first read. The stimulus fills the queue one byte at a time and, at each fill level, steps through all four trigger codes. It then sends one extra byte to check that the byte is dropped, and drains the queue while checking the byte order and the fall of the pin. Character-managed pausing is reached the same way: a stop character is fed in through the receive strobe, and a transmit attempt is made before the resume character arrives.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

   typedef struct packed {
      logic        rtr_sel;
      logic        echo;
      logic        sw_en;
      logic        hw_en;
      logic [1:0]  rsvd;
      logic        rts_bit;
      logic        dtr_bit;
      logic [1:0]  trig;
      logic [20:0] spare;
      logic        fifo_en;
   } ctrl_t;

   typedef enum logic [1:0] {
      TXS_NONE = 2'd0,
      TXS_BUF  = 2'd1,
      TXS_ECHO = 2'd2
   } tx_src_e;

endpackage

// File: rtl/uart_fc_rxq.sv
module uart_fc_rxq #(
   parameter int DW    = 8,
   parameter int DEPTH = 32,
   parameter int LVL0  = 1,
   parameter int LVL1  = 8,
   parameter int LVL2  = 18,
   parameter int LVL3  = 28
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fifo_en,
   input  logic [1:0]                   trig,
   input  logic                         push,
   input  logic [DW-1:0]                push_data,
   input  logic                         pop,
   output logic [DW-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]   fill,
   output logic                         ready_req
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (LVL0 < 1 || LVL0 > LVL1 || LVL1 > LVL2 || LVL2 > LVL3 || LVL3 > DEPTH) begin : g_bad_lvl
         $error("uart_fc_rxq: trigger levels must rise and stay within DEPTH");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_fc_rxq: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt, cap, lvl;
   logic          at_cap, do_push, do_pop;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
   assign at_cap  = (cnt >= cap);
   assign do_pop  = pop && (cnt != '0);
   assign do_push = push && (!at_cap || do_pop);

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= bump(wp);
         if (do_pop)  rp <= bump(rp);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_comb begin
      case (trig)
         2'b00:   lvl = CW'(LVL0);
         2'b01:   lvl = CW'(LVL1);
         2'b10:   lvl = CW'(LVL2);
         default: lvl = CW'(LVL3);
      endcase
   end

   assign head      = mem[rp];
   assign fill      = cnt;
   assign ready_req = fifo_en ? (cnt >= lvl) : (cnt != '0);

   p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && at_cap && !pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/uart_fc_swflow.sv
module uart_fc_swflow #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_en,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic [DW-1:0] xon_char,
   input  logic [DW-1:0] xoff_char,
   output logic          store,
   output logic          stopped
);
   logic is_xoff, is_xon;

   assign is_xoff = sw_en && rx_valid && (rx_data == xoff_char);
   assign is_xon  = sw_en && rx_valid && (rx_data == xon_char);
   assign store   = rx_valid && !is_xoff && !is_xon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stopped <= 1'b0;
      else if (!sw_en)  stopped <= 1'b0;
      else if (is_xoff) stopped <= 1'b1;
      else if (is_xon)  stopped <= 1'b0;
   end

   p_xoff_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_xoff |=> stopped);

   p_xon_resumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_xon && !is_xoff) |=> !stopped);

endmodule

// File: rtl/uart_fc_txsel.sv
module uart_fc_txsel
   import uart_fc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          echo_en,
   input  logic          echo_valid,
   input  logic [DW-1:0] echo_data,
   input  logic          buf_valid,
   input  logic [DW-1:0] buf_data,
   input  logic          shift_ready,
   input  logic          permit,
   output logic          buf_ack,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   tx_src_e src;

   always_comb begin
      if (echo_en)
         src = echo_valid ? TXS_ECHO : TXS_NONE;
      else if (buf_valid && shift_ready && permit)
         src = TXS_BUF;
      else
         src = TXS_NONE;
   end

   assign buf_ack = (src == TXS_BUF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= (src != TXS_NONE);
         case (src)
            TXS_ECHO: out_data <= echo_data;
            TXS_BUF:  out_data <= buf_data;
            default:  out_data <= out_data;
         endcase
      end
   end

   p_ack_emits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      buf_ack |=> (out_valid && out_data == $past(buf_data)));

   p_echo_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (echo_en && echo_valid) |=> (out_valid && out_data == $past(echo_data)));

   p_blocked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!permit && !echo_en) |=> !out_valid);

endmodule

// File: rtl/uart_fc_pins.sv
module uart_fc_pins #(
   parameter bit REG_PINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dtr_nxt,
   input  logic rts_nxt,
   output logic pin_dtr,
   output logic pin_rts
);
   generate
      if (REG_PINS) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pin_dtr <= 1'b1;
               pin_rts <= 1'b1;
            end else begin
               pin_dtr <= dtr_nxt;
               pin_rts <= rts_nxt;
            end
         end
      end else begin : g_comb
         assign pin_dtr = rst_n ? dtr_nxt : 1'b1;
         assign pin_rts = rst_n ? rts_nxt : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
   import uart_fc_pkg::*;
#(
   parameter int DW       = 8,
   parameter int DEPTH    = 32,
   parameter int LVL0     = 1,
   parameter int LVL1     = 8,
   parameter int LVL2     = 18,
   parameter int LVL3     = 28,
   parameter bit REG_PINS = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [31:0]                 ctrl_word,
   input  logic [DW-1:0]               xon_char,
   input  logic [DW-1:0]               xoff_char,
   input  logic                        rx_in_valid,
   input  logic [DW-1:0]               rx_in_data,
   input  logic                        rx_rd,
   output logic [DW-1:0]               rx_out_data,
   output logic [$clog2(DEPTH+1)-1:0]  rx_fill,
   output logic                        rx_ready_req,
   input  logic                        tx_buf_valid,
   input  logic [DW-1:0]               tx_buf_data,
   output logic                        tx_buf_ack,
   input  logic                        tx_shift_ready,
   output logic                        tx_out_valid,
   output logic [DW-1:0]               tx_out_data,
   input  logic                        cts_n,
   output logic                        pin_dtr,
   output logic                        pin_rts
);
   localparam int CW = $clog2(DEPTH + 1);

   ctrl_t c;
   logic  store, stopped, permit;
   logic  rtr_lvl, rts_nxt, dtr_nxt;

   assign c = ctrl_t'(ctrl_word);

   uart_fc_swflow #(.DW(DW)) u_sw (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_en     (c.sw_en),
      .rx_valid  (rx_in_valid),
      .rx_data   (rx_in_data),
      .xon_char  (xon_char),
      .xoff_char (xoff_char),
      .store     (store),
      .stopped   (stopped)
   );

   uart_fc_rxq #(
      .DW(DW), .DEPTH(DEPTH),
      .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
   ) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_en   (c.fifo_en),
      .trig      (c.trig),
      .push      (store),
      .push_data (rx_in_data),
      .pop       (rx_rd),
      .head      (rx_out_data),
      .fill      (rx_fill),
      .ready_req (rx_ready_req)
   );

   assign permit = !(c.hw_en && cts_n) && !(c.sw_en && stopped);

   uart_fc_txsel #(.DW(DW)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .echo_en     (c.echo),
      .echo_valid  (store),
      .echo_data   (rx_in_data),
      .buf_valid   (tx_buf_valid),
      .buf_data    (tx_buf_data),
      .shift_ready (tx_shift_ready),
      .permit      (permit),
      .buf_ack     (tx_buf_ack),
      .out_valid   (tx_out_valid),
      .out_data    (tx_out_data)
   );

   assign rtr_lvl = c.fifo_en ? (rx_fill == CW'(DEPTH)) : (rx_fill != '0);
   assign dtr_nxt = !c.dtr_bit;

   always_comb begin
      if (c.rtr_sel)    rts_nxt = rtr_lvl;
      else if (c.hw_en) rts_nxt = !(tx_buf_valid && !cts_n);
      else              rts_nxt = !c.rts_bit;
   end

   uart_fc_pins #(.REG_PINS(REG_PINS)) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .dtr_nxt (dtr_nxt),
      .rts_nxt (rts_nxt),
      .pin_dtr (pin_dtr),
      .pin_rts (pin_rts)
   );

   generate
      if (REG_PINS) begin : g_pin_chk
         p_dtr_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (pin_dtr == !$past(ctrl_word[24])));
         p_sw_rts_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_word[31] && !ctrl_word[28]) |=> (pin_rts == !$past(ctrl_word[25])));
         p_rtr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_word[31] && ctrl_word[0] && rx_fill == CW'(DEPTH)) |=> pin_rts);
      end
   endgenerate

   p_hw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[28] && cts_n) |-> !tx_buf_ack);

endmodule

// File: tb/sim_uart_flowctl.sv
module sim_uart_flowctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl_word = '0;
   logic [7:0]  xon_char = 8'h11, xoff_char = 8'h13;
   logic        rx_in_valid = 1'b0, rx_rd = 1'b0;
   logic [7:0]  rx_in_data = '0;
   logic [7:0]  rx_out_data;
   logic [5:0]  rx_fill;
   logic        rx_ready_req;
   logic        tx_buf_valid = 1'b0, tx_shift_ready = 1'b0, cts_n = 1'b0;
   logic [7:0]  tx_buf_data = '0;
   logic        tx_buf_ack, tx_out_valid;
   logic [7:0]  tx_out_data;
   logic        pin_dtr, pin_rts;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_flowctl u0 (.*);

   // fields: ctrl[35:4], tx_buf_valid[3], cts_n[2], exp pin_dtr[1], exp pin_rts[0]
   localparam logic [35:0] VEC [10] = '{
      {32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1},
      {32'h0100_0000, 1'b0, 1'b0, 1'b0, 1'b1},
      {32'h0200_0000, 1'b0, 1'b0, 1'b1, 1'b0},
      {32'h0300_0000, 1'b0, 1'b0, 1'b0, 1'b0},
      {32'h1200_0000, 1'b0, 1'b0, 1'b1, 1'b1},
      {32'h1000_0000, 1'b1, 1'b0, 1'b1, 1'b0},
      {32'h1200_0000, 1'b1, 1'b1, 1'b1, 1'b1},
      {32'h8200_0001, 1'b0, 1'b0, 1'b1, 1'b0},
      {32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0},
      {32'h0D00_0000, 1'b0, 1'b0, 1'b0, 1'b1}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      rx_in_valid = 1'b1;
      rx_in_data  = d;
      @(negedge clk);
      rx_in_valid = 1'b0;
   endtask

   task automatic pop1();
      @(negedge clk);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic send_try(input logic [7:0] d, input logic exp_ack, input string req);
      @(negedge clk);
      tx_buf_valid = 1'b1; tx_buf_data = d; tx_shift_ready = 1'b1;
      #1 chk(tx_buf_ack, exp_ack, req);
      @(negedge clk);
      tx_buf_valid = 1'b0; tx_shift_ready = 1'b0;
      chk(tx_out_valid, exp_ack, req);
      if (exp_ack) chk(tx_out_data, d, req);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int lvl [4] = '{1, 8, 18, 28};
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(pin_dtr, 1, "R1"); chk(pin_rts, 1, "R1");
      chk(rx_fill, 0, "R1"); chk(rx_ready_req, 0, "R1"); chk(tx_out_valid, 0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk(pin_dtr, 1, "R1"); chk(pin_rts, 1, "R1");

      // pin vector table (R4 R5 R6 R7), queue empty
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         ctrl_word    = VEC[i][35:4];
         tx_buf_valid = VEC[i][3];
         cts_n        = VEC[i][2];
         @(negedge clk);
         chk(pin_dtr, VEC[i][1], "R4 dtr");
         chk(pin_rts, VEC[i][0], "R5/R6/R7 rts");
      end
      tx_buf_valid = 1'b0; cts_n = 1'b0; ctrl_word = '0;

      // R2 thresholds and R3 depth under RTR meaning
      for (int f = 1; f <= 32; f++) begin
         push(8'h40 + 8'(f - 1));
         chk(rx_fill, f, "R3 fill");
         for (int t = 0; t < 4; t++) begin
            ctrl_word = 32'h8000_0001 | (32'(t) << 22);
            #1 chk(rx_ready_req, (f >= lvl[t]) ? 1 : 0, "R2 trigger");
         end
      end
      @(negedge clk);
      chk(pin_rts, 1, "R7 full");
      push(8'hEE);
      chk(rx_fill, 32, "R3 drop when full");
      for (int i = 0; i < 32; i++) begin
         chk(rx_out_data, 8'h40 + 8'(i), "R3 order");
         pop1();
      end
      chk(rx_fill, 0, "R3 drained");
      @(negedge clk);
      chk(pin_rts, 0, "R7 not full");

      // single-buffer mode
      ctrl_word = 32'h8000_0000;
      push(8'h21);
      chk(rx_fill, 1, "R3 single"); chk(rx_ready_req, 1, "R2 single");
      @(negedge clk);
      chk(pin_rts, 1, "R7 nonempty");
      push(8'h22);
      chk(rx_fill, 1, "R3 single drop");
      chk(rx_out_data, 8'h21, "R3 single keep");
      pop1();
      chk(rx_ready_req, 0, "R2 single empty");

      // R10 plain transmit
      ctrl_word = 32'h0;
      send_try(8'h5A, 1, "R10");
      send_try(8'hA5, 1, "R10");

      // R6 pin-managed flow
      ctrl_word = 32'h1000_0000; cts_n = 1'b1;
      send_try(8'h61, 0, "R6 cts off");
      cts_n = 1'b0;
      send_try(8'h62, 1, "R6 cts on");

      // R8 character-managed flow
      ctrl_word = 32'h2000_0000;
      push(8'h13);
      chk(rx_fill, 0, "R8 xoff not stored");
      send_try(8'h31, 0, "R8 halted");
      push(8'h11);
      chk(rx_fill, 0, "R8 xon not stored");
      send_try(8'h32, 1, "R8 resumed");
      ctrl_word = 32'h0;
      push(8'h13);
      chk(rx_fill, 1, "R8 stored when off");
      pop1();

      // R9 echo
      ctrl_word = 32'h4000_0000;
      @(negedge clk);
      rx_in_valid = 1'b1; rx_in_data = 8'h77;
      tx_buf_valid = 1'b1; tx_buf_data = 8'h99; tx_shift_ready = 1'b1;
      #1 chk(tx_buf_ack, 0, "R9 buffer held");
      @(negedge clk);
      rx_in_valid = 1'b0;
      chk(tx_out_valid, 1, "R9 echo strobe");
      chk(tx_out_data, 8'h77, "R9 echo data");
      chk(rx_fill, 1, "R9 stored");
      chk(tx_buf_ack, 0, "R9 buffer held");
      tx_buf_valid = 1'b0; tx_shift_ready = 1'b0;
      pop1();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule